// File: doc/BRIEF.md
# Instruction Cache Invalidation Control

This block holds the control register of an instruction cache together with the array of per-entry valid bits that the lookup logic reads. Software writes the control register to turn the cache on, freeze it, permit burst line fills, or invalidate cached instructions. Two command bits in the register act only at the instant of the write and are never stored. One flushes the whole cache. The other invalidates a single long-word entry, chosen by an index taken from the contents of a separate cache address register.

The fill logic raises `fill_en` with an entry index to mark that entry valid. The lookup logic presents an index and receives that entry's valid bit one clock later. The whole-cache flush clears every valid flop in a single clock. A fill that arrives in the same clock as the flush is dropped. Lookup, tag comparison and burst sequencing are done by neighbouring blocks.

Top module: `icache_inval_ctrl`

## Requirements
- R1: Control bit 4 is the burst-fill permit. It is loaded on every register write, driven on `burst_en` and read back at bit 4.
- R2: A register write with bit 3 set clears every valid bit at that clock edge. A fill requested in the same cycle is dropped.
- R3: Bit 3 of `reg_rd_data` always reads 0.
- R4: A register write with bit 2 set and bit 3 clear clears only the valid bit of the entry whose index is `addr_reg[ENTRY_W+1:2]`. That index is the set index followed by the long-word select. All other entries keep their state.
- R5: The single-entry clear of R4 takes effect whatever the values of the enable bit (bit 0) and the freeze bit (bit 1), whether those are already stored or written in the same cycle.
- R6: Bit 2 of `reg_rd_data` always reads 0.
- R7: A write with both bit 3 and bit 2 set performs the whole-cache clear.
- R8: Bit 0 (enable) and bit 1 (freeze) are loaded on every write, read back in place and driven on `cache_en` and `cache_frz`. Bits 31:5 read 0. Without a write, the register holds its value.
- R9: `fill_en` sets the valid bit of entry `fill_idx` at the clock edge. A single-entry clear of the same index in the same cycle wins over the fill.
- R10: `lkp_valid` is registered. It shows the valid bit of entry `lkp_idx` as it stood just before the clock edge that sampled `lkp_idx`.
- R11: Synchronous reset `rst` zeroes the control register, all valid bits and `lkp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | DATA_W | Control register write value |
| reg_rd_data | output | DATA_W | Control register read value |
| addr_reg | input | DATA_W | Contents of the cache address register |
| fill_en | input | 1 | Mark entry `fill_idx` valid |
| fill_idx | input | ENTRY_W | Entry being filled |
| lkp_idx | input | ENTRY_W | Entry being looked up |
| lkp_valid | output | 1 | Registered valid bit of the looked-up entry |
| burst_en | output | 1 | Burst-fill permit |
| cache_en | output | 1 | Cache enable |
| cache_frz | output | 1 | Cache freeze |

## Verification
The properties assume that every input is held at zero while `rst` is high. They also assume that the address register field beyond bit `ENTRY_W+1` has no meaning. The "holds without a write" and "fill sets its entry" properties therefore look only at cycles after reset. The stimulus drives all inputs to zero during reset and changes them only on the falling clock edge. It uses entry indices below 64, so every index fits the default field width, and it places fills and clears on the same and on different entries so that each precedence case occurs.

// File: rtl/icache_ctl_pkg.sv
package icache_ctl_pkg;

  // Bit positions in the control register
  localparam int unsigned CB_ENABLE  = 0;
  localparam int unsigned CB_FREEZE  = 1;
  localparam int unsigned CB_CLR_ONE = 2;
  localparam int unsigned CB_CLR_ALL = 3;
  localparam int unsigned CB_BURST   = 4;

  // Stored part of the control register
  typedef struct packed {
    logic burst;
    logic freeze;
    logic enable;
  } ctl_state_t;

endpackage

// File: rtl/icache_ctl_regs.sv
module icache_ctl_regs
  import icache_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_state_t        state_q,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else if (wr_en) begin
      state_q.burst  <= wr_data[CB_BURST];
      state_q.freeze <= wr_data[CB_FREEZE];
      state_q.enable <= wr_data[CB_ENABLE];
    end
  end

  // Read value: built only from the stored flops. Command bits read 0.
  always_comb begin
    rd_data              = '0;
    rd_data[CB_ENABLE]   = state_q.enable;
    rd_data[CB_FREEZE]   = state_q.freeze;
    rd_data[CB_BURST]    = state_q.burst;
  end

endmodule

// File: rtl/icache_cmd_decode.sv
module icache_cmd_decode
  import icache_ctl_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ENTRY_W  = 6,
  parameter int unsigned ADDR_LSB = 2
) (
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [DATA_W-1:0]  addr_reg,
  output logic               clr_all,
  output logic               clr_one,
  output logic [ENTRY_W-1:0] clr_idx
);

  // Whole-cache clear has priority over the single-entry clear.
  // Neither depends on the enable or freeze state.
  always_comb begin
    clr_all = wr_en && wr_data[CB_CLR_ALL];
    clr_one = wr_en && wr_data[CB_CLR_ONE] && !wr_data[CB_CLR_ALL];
    clr_idx = addr_reg[ADDR_LSB +: ENTRY_W];
  end

endmodule

// File: rtl/icache_valid_array.sv
module icache_valid_array #(
  parameter int unsigned ENTRY_W = 6,
  localparam int unsigned NUM_ENT = 1 << ENTRY_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_all,
  input  logic               clr_one,
  input  logic [ENTRY_W-1:0] clr_idx,
  input  logic               fill_en,
  input  logic [ENTRY_W-1:0] fill_idx,
  input  logic [ENTRY_W-1:0] lkp_idx,
  output logic [NUM_ENT-1:0] valid_q,
  output logic               lkp_valid
);

  logic [NUM_ENT-1:0] clr_sel;
  logic [NUM_ENT-1:0] fill_sel;

  always_comb begin
    clr_sel  = clr_one ? (NUM_ENT'(1) << clr_idx)  : '0;
    fill_sel = fill_en ? (NUM_ENT'(1) << fill_idx) : '0;
  end

  // Flops, not RAM: the whole-cache clear needs every bit in one edge.
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        valid_q[g] <= 1'b0;
      end else if (clr_sel[g]) begin
        valid_q[g] <= 1'b0;
      end else if (fill_sel[g]) begin
        valid_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lkp_valid <= 1'b0;
    end else begin
      lkp_valid <= valid_q[lkp_idx];
    end
  end

endmodule

// File: rtl/icache_inval_ctrl.sv
module icache_inval_ctrl
  import icache_ctl_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned INDEX_W   = 4,
  parameter int unsigned LWSEL_W   = 2,
  parameter int unsigned ADDR_LSB  = 2,
  localparam int unsigned ENTRY_W  = INDEX_W + LWSEL_W,
  localparam int unsigned NUM_ENT  = 1 << ENTRY_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_en,
  input  logic [DATA_W-1:0]  reg_wr_data,
  output logic [DATA_W-1:0]  reg_rd_data,
  input  logic [DATA_W-1:0]  addr_reg,
  input  logic               fill_en,
  input  logic [ENTRY_W-1:0] fill_idx,
  input  logic [ENTRY_W-1:0] lkp_idx,
  output logic               lkp_valid,
  output logic               burst_en,
  output logic               cache_en,
  output logic               cache_frz
);

  ctl_state_t         ctl_q;
  logic               clr_all;
  logic               clr_one;
  logic [ENTRY_W-1:0] clr_idx;
  logic [NUM_ENT-1:0] valid_vec;

  icache_ctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .state_q (ctl_q),
    .rd_data (reg_rd_data)
  );

  icache_cmd_decode #(
    .DATA_W   (DATA_W),
    .ENTRY_W  (ENTRY_W),
    .ADDR_LSB (ADDR_LSB)
  ) u_dec (
    .wr_en    (reg_wr_en),
    .wr_data  (reg_wr_data),
    .addr_reg (addr_reg),
    .clr_all  (clr_all),
    .clr_one  (clr_one),
    .clr_idx  (clr_idx)
  );

  icache_valid_array #(.ENTRY_W(ENTRY_W)) u_valid (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (clr_all),
    .clr_one   (clr_one),
    .clr_idx   (clr_idx),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .lkp_idx   (lkp_idx),
    .valid_q   (valid_vec),
    .lkp_valid (lkp_valid)
  );

  assign burst_en  = ctl_q.burst;
  assign cache_en  = ctl_q.enable;
  assign cache_frz = ctl_q.freeze;

endmodule

// File: rtl/icache_inval_ctrl_chk.sv
module icache_inval_ctrl_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ENTRY_W  = 6,
  parameter int unsigned ADDR_LSB = 2,
  localparam int unsigned NUM_ENT = 1 << ENTRY_W
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr_en,
  input logic [DATA_W-1:0]  reg_wr_data,
  input logic [DATA_W-1:0]  reg_rd_data,
  input logic [DATA_W-1:0]  addr_reg,
  input logic               fill_en,
  input logic [ENTRY_W-1:0] fill_idx,
  input logic               burst_en,
  input logic [NUM_ENT-1:0] valid_vec
);

  logic [ENTRY_W-1:0] sel_idx;
  assign sel_idx = addr_reg[ADDR_LSB +: ENTRY_W];

  p_burst_follows_write_r1: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> burst_en == $past(reg_wr_data[4]));

  p_clear_all_empties_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_wr_data[3]) |=> valid_vec == '0);

  p_clr_all_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
    reg_rd_data[3] == 1'b0);

  p_clear_one_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_wr_data[2] && !reg_wr_data[3]) |=> !valid_vec[$past(sel_idx)]);

  p_clr_one_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
    reg_rd_data[2] == 1'b0);

  p_both_cmds_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_wr_data[3] && reg_wr_data[2]) |=> $countones(valid_vec) == 0);

  p_ctrl_holds_r8: assert property (@(posedge clk) disable iff (rst)
    !reg_wr_en |=> $stable(reg_rd_data));

  p_fill_sets_entry_r9: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !(reg_wr_en && (reg_wr_data[3] || (reg_wr_data[2] && sel_idx == fill_idx))))
      |=> valid_vec[$past(fill_idx)]);

endmodule

bind icache_inval_ctrl icache_inval_ctrl_chk #(
  .DATA_W   (DATA_W),
  .ENTRY_W  (ENTRY_W),
  .ADDR_LSB (ADDR_LSB)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_data (reg_rd_data),
  .addr_reg    (addr_reg),
  .fill_en     (fill_en),
  .fill_idx    (fill_idx),
  .burst_en    (burst_en),
  .valid_vec   (valid_vec)
);

// File: tb/icache_inval_ctrl_test.sv
module icache_inval_ctrl_test;

  localparam int DW = 32;
  localparam int EW = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic          reg_wr_en;
  logic [DW-1:0] reg_wr_data;
  logic [DW-1:0] reg_rd_data;
  logic [DW-1:0] addr_reg;
  logic          fill_en;
  logic [EW-1:0] fill_idx;
  logic [EW-1:0] lkp_idx;
  logic          lkp_valid;
  logic          burst_en;
  logic          cache_en;
  logic          cache_frz;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  icache_inval_ctrl uut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .addr_reg(addr_reg), .fill_en(fill_en), .fill_idx(fill_idx),
    .lkp_idx(lkp_idx), .lkp_valid(lkp_valid),
    .burst_en(burst_en), .cache_en(cache_en), .cache_frz(cache_frz)
  );

  always #4 clk = ~clk;

  // Row: wr | data[4:0] | addr idx | fill | fill idx | lkp idx | exp rd[4:0] | exp lkp
  localparam int NROW = 18;
  localparam logic [30:0] TBL [NROW] = '{
    {1'b0, 5'h00, 6'd0,  1'b1, 6'd5,  6'd5,  5'h00, 1'b0},
    {1'b0, 5'h00, 6'd0,  1'b1, 6'd9,  6'd5,  5'h00, 1'b1},
    {1'b0, 5'h00, 6'd0,  1'b1, 6'd12, 6'd9,  5'h00, 1'b1},
    {1'b1, 5'h13, 6'd0,  1'b0, 6'd0,  6'd12, 5'h13, 1'b1},
    {1'b1, 5'h07, 6'd9,  1'b0, 6'd0,  6'd9,  5'h03, 1'b1},
    {1'b0, 5'h00, 6'd0,  1'b0, 6'd0,  6'd9,  5'h03, 1'b0},
    {1'b0, 5'h00, 6'd0,  1'b0, 6'd0,  6'd5,  5'h03, 1'b1},
    {1'b0, 5'h00, 6'd0,  1'b0, 6'd0,  6'd12, 5'h03, 1'b1},
    {1'b1, 5'h08, 6'd0,  1'b1, 6'd20, 6'd5,  5'h00, 1'b1},
    {1'b0, 5'h00, 6'd0,  1'b0, 6'd0,  6'd5,  5'h00, 1'b0},
    {1'b0, 5'h00, 6'd0,  1'b0, 6'd0,  6'd20, 5'h00, 1'b0},
    {1'b0, 5'h00, 6'd0,  1'b1, 6'd30, 6'd12, 5'h00, 1'b0},
    {1'b1, 5'h04, 6'd31, 1'b1, 6'd31, 6'd30, 5'h00, 1'b1},
    {1'b0, 5'h00, 6'd0,  1'b0, 6'd0,  6'd31, 5'h00, 1'b0},
    {1'b0, 5'h00, 6'd0,  1'b1, 6'd40, 6'd30, 5'h00, 1'b1},
    {1'b1, 5'h0C, 6'd0,  1'b0, 6'd0,  6'd40, 5'h00, 1'b1},
    {1'b0, 5'h00, 6'd0,  1'b0, 6'd0,  6'd40, 5'h00, 1'b0},
    {1'b1, 5'h10, 6'd0,  1'b0, 6'd0,  6'd30, 5'h10, 1'b0}
  };

  function automatic string row_tag(int i);
    case (i)
      0, 1, 12, 13, 14: return "R9";
      2:                return "R10";
      3:                return "R8";
      4:                return "R5";
      5, 6, 7:          return "R4";
      8, 9, 10, 11:     return "R2";
      15, 16:           return "R7";
      default:          return "R1";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr_en = 1'b0; reg_wr_data = '0; addr_reg = '0;
    fill_en = 1'b0; fill_idx = '0; lkp_idx = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;

    // Reset state
    check("R11", "rd after reset", reg_rd_data, '0);
    check("R11", "burst after reset", {31'd0, burst_en}, '0);
    check("R11", "lkp after reset", {31'd0, lkp_valid}, '0);

    // Table walk
    for (int i = 0; i < NROW; i++) begin
      reg_wr_en   = TBL[i][30];
      reg_wr_data = {27'd0, TBL[i][29:25]};
      addr_reg    = {24'd0, TBL[i][24:19], 2'b00};
      fill_en     = TBL[i][18];
      fill_idx    = TBL[i][17:12];
      lkp_idx     = TBL[i][11:6];
      step();
      check(row_tag(i), "rd", reg_rd_data, {27'd0, TBL[i][5:1]});
      check(row_tag(i), "lkp", {31'd0, lkp_valid}, {31'd0, TBL[i][0]});
    end
    idle();

    // R1 / R8: outputs follow stored bits
    check("R1", "burst_en", {31'd0, burst_en}, 32'd1);
    check("R8", "cache_en", {31'd0, cache_en}, 32'd0);

    // R3 R6 R8: all ones written -> commands and upper bits read 0
    reg_wr_en = 1'b1; reg_wr_data = '1;
    step();
    idle();
    check("R3", "rd bit3", {31'd0, reg_rd_data[3]}, 32'd0);
    check("R6", "rd bit2", {31'd0, reg_rd_data[2]}, 32'd0);
    check("R8", "rd all-ones write", reg_rd_data, 32'h13);
    check("R8", "cache_en/frz", {30'd0, cache_frz, cache_en}, 32'd3);
    step();
    check("R8", "rd holds without write", reg_rd_data, 32'h13);

    // R5: clear-entry with enable and freeze already set
    fill_en = 1'b1; fill_idx = 6'd63;
    step();
    idle();
    reg_wr_en = 1'b1; reg_wr_data = 32'h07; addr_reg = {24'd0, 6'd63, 2'b00};
    step();
    idle();
    lkp_idx = 6'd63;
    step();
    check("R5", "entry 63 cleared with en/frz set", {31'd0, lkp_valid}, 32'd0);

    // R11: reset mid-run clears a filled entry and the register
    idle();
    fill_en = 1'b1; fill_idx = 6'd7;
    step();
    idle();
    lkp_idx = 6'd7;
    step();
    check("R9", "entry 7 filled", {31'd0, lkp_valid}, 32'd1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R11", "rd after mid reset", reg_rd_data, '0);
    lkp_idx = 6'd7;
    step();
    check("R11", "entry 7 after mid reset", {31'd0, lkp_valid}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule